// File: doc/BRIEF.md
# Pixel Byte Packet Serializer

This block turns a pixel-rate stream of output bytes, together with their line-valid and frame-valid flags, into one serial bit stream. Every byte becomes a fixed packet of twelve bits, framed by a start bit and a stop bit, with both flags carried inside the packet. The block runs on a single bit clock at twelve times the pixel rate. An upstream formatter presents one byte per packet slot with a one-cycle strobe, and the serial bit goes out one per bit clock. The serializer does not interpret the byte, so raw, processed and two-byte 10-bit bypass formats all pass through it unchanged.

A free-running modulo-twelve counter defines the slot grid. A byte is accepted only at the slot boundary, and a strobe anywhere else is reported as a protocol error. When no byte is offered at a boundary, a blanking packet with zero data and cleared flags is sent, so packets always follow back to back. An output-enable releases the line during reset and standby. Standby is sampled only at slot boundaries, so a packet in flight always finishes before the enable drops.

Top module: `ser_pixel_packetizer`

## Requirements
- R1: A packet has twelve bits. Bit 0 is the start bit, driven 1. Bits 1 to 8 carry data bits 0 to 7. Bit 9 is line-valid, bit 10 is frame-valid, and bit 11 is the stop bit, driven 0.
- R2: Packet bits leave in order from bit 0 to bit 11, one per clock, so the byte goes out least significant bit first. A byte whose strobe is sampled at boundary edge E shows bit k on `ser_bit` after edge E+k.
- R3: While the link is enabled, each packet follows the previous one with no idle bit between them.
- R4: If no strobe is sampled at a boundary edge and standby is low, a blanking packet is sent: start 1, data 0, line-valid 0, frame-valid 0, stop 0.
- R5: A strobe sampled at an edge that is not a boundary raises `proto_err` for exactly the following cycle, and its byte is never sent.
- R6: During reset, `ser_oe` and `ser_bit` are 0. The first boundary edge is the first rising edge at which reset is low, and boundaries then recur every twelve edges.
- R7: Standby is sampled only at boundary edges. If it is high there, no packet is loaded and `ser_oe` is 0 for that whole slot. A packet already being sent is always completed.
- R8: Whenever `ser_oe` is 0, `ser_bit` is 0.
- R9: When standby is low again at a boundary edge, the link re-enables and a packet starts on the next cycle.
- R10: A strobe sampled at a boundary edge while standby is high is dropped and does not raise `proto_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, twelve times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Request to release the line, honoured at slot boundaries |
| pix_stb | input | 1 | One-cycle byte strobe, valid at slot boundaries |
| pix_data | input | DATA_W | Output byte to be framed |
| pix_lv | input | 1 | Line-valid flag for the byte |
| pix_fv | input | 1 | Frame-valid flag for the byte |
| ser_bit | output | 1 | Serial packet bit |
| ser_oe | output | 1 | Serial line enable, low means released |
| proto_err | output | 1 | One-cycle pulse for a strobe off the slot boundary |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, which gives a 12-bit packet, a start level of 1 and a stop level of 0. This is the exact packet an off-the-shelf deserializer expects, so the bench can rebuild every packet from its own concatenation. With a 12-cycle slot, a full sequence is short enough to cover many cases in one run. That sequence includes pixel packets, blanking packets, a strobe misplaced inside a slot, standby raised in the middle of a packet, a strobe offered during standby, and the resume.

// File: rtl/ser_pkt_pkg.sv
package ser_pkt_pkg;

  typedef enum logic {
    LINK_OFF = 1'b0,
    LINK_ON  = 1'b1
  } link_state_e;

  function automatic int slot_len(input int data_w);
    return data_w + 4;
  endfunction

endpackage

// File: rtl/ser_slot_counter.sv
module ser_slot_counter #(
  parameter int PKT_W = 12,
  localparam int IDX_W = $clog2(PKT_W)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] bit_idx,
  output logic             slot_end
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_W - 1);

  assign slot_end = (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= LAST;
    end else if (slot_end) begin
      bit_idx <= '0;
    end else begin
      bit_idx <= bit_idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/ser_link_ctrl.sv
module ser_link_ctrl
  import ser_pkt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic slot_end,
  input  logic standby,
  input  logic pix_stb,
  output logic load_en,
  output logic take_pixel,
  output logic link_on,
  output logic proto_err
);

  link_state_e state_q;
  link_state_e state_d;

  assign load_en    = slot_end && !standby;
  assign take_pixel = load_en && pix_stb;

  always_comb begin
    state_d = state_q;
    if (slot_end) begin
      state_d = standby ? LINK_OFF : LINK_ON;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LINK_OFF;
      proto_err <= 1'b0;
    end else begin
      state_q   <= state_d;
      proto_err <= pix_stb && !slot_end;
    end
  end

  assign link_on = (state_q == LINK_ON);

endmodule

// File: rtl/ser_packet_shifter.sv
module ser_packet_shifter #(
  parameter int   DATA_W    = 8,
  parameter logic START_LVL = 1'b1,
  parameter logic STOP_LVL  = 1'b0,
  localparam int  PKT_W     = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              take_pixel,
  input  logic [DATA_W-1:0] data,
  input  logic              lv,
  input  logic              fv,
  output logic              bit_out
);

  localparam int LV_POS = DATA_W + 1;
  localparam int FV_POS = DATA_W + 2;

  function automatic logic [PKT_W-1:0] frame_word(
    input logic [DATA_W-1:0] d,
    input logic              l,
    input logic              f
  );
    logic [PKT_W-1:0] w;
    w = '0;
    w[0] = START_LVL;
    for (int i = 0; i < DATA_W; i++) begin
      w[1 + i] = d[i];
    end
    w[LV_POS]    = l;
    w[FV_POS]    = f;
    w[PKT_W - 1] = STOP_LVL;
    return w;
  endfunction

  logic [PKT_W-1:0] shreg;
  logic [PKT_W-1:0] next_word;

  assign next_word = take_pixel ? frame_word(data, lv, fv)
                                : frame_word('0, 1'b0, 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (load_en) begin
      shreg <= next_word;
    end else begin
      shreg <= {1'b0, shreg[PKT_W-1:1]};
    end
  end

  assign bit_out = shreg[0];

endmodule

// File: rtl/ser_pixel_packetizer.sv
module ser_pixel_packetizer #(
  parameter int   DATA_W    = 8,
  parameter logic START_LVL = 1'b1,
  parameter logic STOP_LVL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              pix_stb,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_lv,
  input  logic              pix_fv,
  output logic              ser_bit,
  output logic              ser_oe,
  output logic              proto_err
);

  localparam int PKT_W = ser_pkt_pkg::slot_len(DATA_W);
  localparam int IDX_W = $clog2(PKT_W);

  logic [IDX_W-1:0] bit_idx;
  logic             slot_end;
  logic             load_en;
  logic             take_pixel;
  logic             link_on;
  logic             raw_bit;

  ser_slot_counter #(
    .PKT_W(PKT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .bit_idx  (bit_idx),
    .slot_end (slot_end)
  );

  ser_link_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .slot_end   (slot_end),
    .standby    (standby),
    .pix_stb    (pix_stb),
    .load_en    (load_en),
    .take_pixel (take_pixel),
    .link_on    (link_on),
    .proto_err  (proto_err)
  );

  ser_packet_shifter #(
    .DATA_W    (DATA_W),
    .START_LVL (START_LVL),
    .STOP_LVL  (STOP_LVL)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .take_pixel (take_pixel),
    .data       (pix_data),
    .lv         (pix_lv),
    .fv         (pix_fv),
    .bit_out    (raw_bit)
  );

  assign ser_oe  = link_on;
  assign ser_bit = link_on & raw_bit;

endmodule

// File: rtl/ser_pixel_packetizer_chk.sv
module ser_pixel_packetizer_chk #(
  parameter int   PKT_W     = 12,
  parameter logic START_LVL = 1'b1,
  parameter logic STOP_LVL  = 1'b0,
  localparam int  IDX_W     = $clog2(PKT_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_stb,
  input logic             ser_bit,
  input logic             ser_oe,
  input logic             proto_err,
  input logic [IDX_W-1:0] bit_idx,
  input logic             slot_end
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_W - 1);

  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ser_oe && bit_idx == '0) |-> (ser_bit == START_LVL)); // R1

  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ser_oe && bit_idx == LAST) |-> (ser_bit == STOP_LVL)); // R1

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (bit_idx == LAST) |=> (bit_idx == '0)); // R2

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(pix_stb) && !$past(slot_end))); // R5

  AST_OE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (ser_oe != $past(ser_oe)) |-> (bit_idx == '0)); // R7

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> !ser_bit); // R8

endmodule

bind ser_pixel_packetizer ser_pixel_packetizer_chk #(
  .PKT_W     (PKT_W),
  .START_LVL (START_LVL),
  .STOP_LVL  (STOP_LVL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_stb   (pix_stb),
  .ser_bit   (ser_bit),
  .ser_oe    (ser_oe),
  .proto_err (proto_err),
  .bit_idx   (bit_idx),
  .slot_end  (slot_end)
);

// File: tb/test_ser_pixel_packetizer.sv
module test_ser_pixel_packetizer;

  localparam int PKT = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       standby = 1'b0;
  logic       pix_stb = 1'b0;
  logic [7:0] pix_data = '0;
  logic       pix_lv = 1'b0;
  logic       pix_fv = 1'b0;
  logic       ser_bit;
  logic       ser_oe;
  logic       proto_err;

  always #2.5 clk = ~clk;

  ser_pixel_packetizer i_ser_pixel_packetizer (
    .clk       (clk),
    .rst       (rst),
    .standby   (standby),
    .pix_stb   (pix_stb),
    .pix_data  (pix_data),
    .pix_lv    (pix_lv),
    .pix_fv    (pix_fv),
    .ser_bit   (ser_bit),
    .ser_oe    (ser_oe),
    .proto_err (proto_err)
  );

  int checks = 0;
  int fails  = 0;
  logic [PKT-1:0] exp_q[$];
  logic err_exp = 1'b0;
  logic done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PKT-1:0] pkt_of(input logic [7:0] d,
                                            input logic lv, input logic fv);
    return {1'b0, fv, lv, d, 1'b1};
  endfunction

  // Driver: one call spans one slot; starts at the negedge before a boundary edge
  task automatic slot(input logic stb, input logic [7:0] d, input logic lv,
                      input logic fv, input logic sb, input int glitch_at,
                      input int sb_rise_at);
    standby  = sb;
    pix_stb  = stb;
    pix_data = d;
    pix_lv   = lv;
    pix_fv   = fv;
    if (!sb) begin
      if (stb) exp_q.push_back(pkt_of(d, lv, fv));   // R1 R2
      else     exp_q.push_back(pkt_of(8'h00, 1'b0, 1'b0)); // R4 blanking
    end
    for (int i = 1; i < PKT; i++) begin
      @(negedge clk);
      pix_stb = (i == glitch_at);
      err_exp = (i == glitch_at);
      if (i == glitch_at) pix_data = 8'h77;
      if (i == sb_rise_at) standby = 1'b1;
    end
    @(negedge clk);
    pix_stb = 1'b0;
    err_exp = 1'b0;
  endtask

  // Monitor: samples 1 ns after each rising edge
  int nbits = 0;
  logic [PKT-1:0] got;
  always begin
    @(posedge clk);
    #1;
    if (rst) begin
      check(!ser_oe && !ser_bit, "R6", "line driven in reset", {ser_oe, ser_bit}, 0);
    end else begin
      check(proto_err == err_exp, "R5", "proto_err", proto_err, err_exp);
      if (ser_oe) begin
        got[nbits] = ser_bit;
        nbits++;
        if (nbits == PKT) begin
          nbits = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected packet", got, 0);
          end else begin
            logic [PKT-1:0] e;
            e = exp_q.pop_front();
            check(got == e, "R1", "packet content", got, e);
          end
        end
      end else begin
        check(!ser_bit, "R8", "ser_bit while released", ser_bit, 0);
        if (nbits != 0) begin
          check(1'b0, "R7", "truncated packet bits", nbits, PKT);
          nbits = 0;
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "R3", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R2 R3: consecutive pixel packets
    slot(1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, -1, -1);
    slot(1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, -1, -1);
    slot(1'b1, 8'h01, 1'b0, 1'b1, 1'b0, -1, -1);
    slot(1'b1, 8'h80, 1'b1, 1'b0, 1'b0, -1, -1);
    // R4: no strobe gives a blanking packet
    slot(1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, -1, -1);
    slot(1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, -1, -1);
    // R5: strobe mid-slot is flagged and not sent
    slot(1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, 5, -1);
    slot(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 11, -1);
    // R7: standby raised mid-packet; packet completes
    slot(1'b1, 8'hC3, 1'b1, 1'b1, 1'b0, -1, 6);
    // R10: strobe during standby is dropped without error
    slot(1'b1, 8'h96, 1'b1, 1'b1, 1'b1, -1, -1);
    check(ser_oe == 1'b0, "R7", "oe in standby slot", ser_oe, 0);
    slot(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, -1, -1);
    // R9: resume on the next boundary with standby low
    slot(1'b1, 8'h69, 1'b1, 1'b1, 1'b0, -1, -1);
    check(ser_oe == 1'b1, "R9", "oe after resume", ser_oe, 1);
    slot(1'b1, 8'hE7, 1'b0, 1'b0, 1'b0, -1, -1);
    slot(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, -1, -1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3", "packets left unsent", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule